// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block holds the operating mode of a small microcontroller core and picks the next mode. It reacts to two strobes. A sleep request arrives when the core executes its halt instruction. A wake event arrives when an interrupt or similar source ends a low-power state. Seven modes exist: two running modes on the main clock (full speed and divided speed), one running mode on the slow subclock (subactive), and four low-power states. The low-power states are sleep, subsleep, software standby and watch.

One control bit, `lo_spd`, splits the transitions into two paths. With `lo_spd` low, a sleep request keeps the system on the main-clock path, and leaving watch returns to full speed. With `lo_spd` high, a sleep request moves toward the subclock, and leaving watch returns to subactive. Where two destinations are allowed, `stby_sel` and `dir_xfer` choose between them. A mode that needs the subclock is refused while `sub_stop` disables that clock. The block also drives the two clock enables and the ratio of the sampling strobe used by the subclock noise filter.

Top module: `lpm_mode_ctrl`

## Requirements
- R1: After reset, `mode` is full speed (code 0) and `main_clk_en` is 1. Mode codes are: 0 full speed, 1 divided speed, 2 subactive, 3 sleep, 4 subsleep, 5 software standby, 6 watch.
- R2: In full or divided speed with no sleep request, the next mode is divided speed when `div_sel` is 1 and full speed when it is 0.
- R3: With `lo_spd`=0, a sleep request in full or divided speed behaves as follows:
  - `stby_sel`=0 leads to sleep.
  - `stby_sel`=1 and `dir_xfer`=0 lead to software standby.
  - `stby_sel`=1 and `dir_xfer`=1 lead to watch.
- R4: With `lo_spd`=1, a sleep request in full or divided speed leads to watch when `stby_sel`=1 and to subactive otherwise.
- R5: With `lo_spd`=0, a sleep request in subactive leads to full speed when `dir_xfer`=1 and to watch otherwise.
- R6: With `lo_spd`=1, a sleep request in subactive leads to watch when `stby_sel`=1 and to subsleep otherwise.
- R7: While `sub_stop`=1, any transition into subactive, subsleep or watch is refused, and the mode stays unchanged.
- R8: A wake event moves sleep to full speed, software standby to full speed, and subsleep to subactive.
- R9: A wake event in watch leads to full speed when `lo_spd`=0 and to subactive when `lo_spd`=1.
- R10: In a low-power mode, a sleep request without a wake event leaves the mode unchanged. In subactive, no sleep request leaves the mode unchanged.
- R11: `main_clk_en` is 0 in software standby, watch, subactive and subsleep, and 1 in every other mode. `sub_clk_en` is the inverse of `sub_stop`.
- R12: `smp_div` is FAST_DIV (4) when `nf_fast`=1 and SLOW_DIV (32) when `nf_fast`=0.
- Every mode change takes effect on the clock edge after the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep-instruction strobe |
| wake_evt | input | 1 | Wake-up / cancel strobe |
| lo_spd | input | 1 | Selects the subclock path for sleep and watch exit |
| stby_sel | input | 1 | Standby / watch destination select |
| dir_xfer | input | 1 | Direct-transfer destination select |
| sub_stop | input | 1 | 1 disables subclock generation |
| nf_fast | input | 1 | Noise-filter sampling rate select |
| div_sel | input | 1 | Selects divided speed while running on the main clock |
| mode | output | 3 | Current operating mode code |
| main_clk_en | output | 1 | Main clock enable |
| sub_clk_en | output | 1 | Subclock enable |
| smp_div | output | 6 | Sampling strobe division ratio for the subclock filter |

## Verification
The bench builds the block with the default ratios, FAST_DIV=4 and SLOW_DIV=32, so `smp_div` is six bits wide. Both ratio values can be told apart at the port. The mode set is fixed, so a random walk of a few thousand cycles reaches every mode. The walk uses a `sub_stop` bias that is low but not zero. It therefore also reaches each refused transition into a subclock mode, from each running mode and from watch with `lo_spd` set.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_FULL   = 3'd0,
    M_DIV    = 3'd1,
    M_SUBACT = 3'd2,
    M_SLEEP  = 3'd3,
    M_SUBSLP = 3'd4,
    M_STBY   = 3'd5,
    M_WATCH  = 3'd6
  } mode_e;

  // modes that run only on the subclock
  function automatic logic needs_sub(mode_e m);
    return (m == M_SUBACT) || (m == M_SUBSLP) || (m == M_WATCH);
  endfunction

  // main oscillator enabled
  function automatic logic main_on(mode_e m);
    return !((m == M_STBY) || (m == M_WATCH) || (m == M_SUBACT) || (m == M_SUBSLP));
  endfunction

  // low-power states left only by a wake event
  function automatic logic is_parked(mode_e m);
    return (m == M_SLEEP) || (m == M_SUBSLP) || (m == M_STBY) || (m == M_WATCH);
  endfunction

  function automatic logic [7:0] pick_div(logic fast, logic [7:0] f, logic [7:0] s);
    return fast ? f : s;
  endfunction
endpackage

// File: rtl/lpm_next_mode.sv
module lpm_next_mode
  import lpm_pkg::*;
(
  input  mode_e cur,
  input  logic  sleep_req,
  input  logic  wake_evt,
  input  logic  lo_spd,
  input  logic  stby_sel,
  input  logic  dir_xfer,
  input  logic  sub_off,
  input  logic  div_sel,
  output mode_e nxt,
  output logic  refused
);
  mode_e tgt;

  always_comb begin
    tgt = cur;
    case (cur)
      M_FULL, M_DIV: begin
        if (sleep_req) begin
          if (lo_spd)         tgt = stby_sel ? M_WATCH : M_SUBACT;
          else if (!stby_sel) tgt = M_SLEEP;
          else                tgt = dir_xfer ? M_WATCH : M_STBY;
        end else begin
          tgt = div_sel ? M_DIV : M_FULL;
        end
      end
      M_SUBACT: begin
        if (sleep_req) begin
          if (lo_spd) tgt = stby_sel ? M_WATCH : M_SUBSLP;
          else        tgt = dir_xfer ? M_FULL : M_WATCH;
        end
      end
      M_SLEEP, M_STBY: if (wake_evt) tgt = M_FULL;
      M_SUBSLP:        if (wake_evt) tgt = M_SUBACT;
      M_WATCH:         if (wake_evt) tgt = lo_spd ? M_SUBACT : M_FULL;
      default:         tgt = M_FULL;
    endcase
  end

  assign refused = sub_off && needs_sub(tgt) && (tgt != cur);
  assign nxt     = refused ? cur : tgt;
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 32,
  localparam int DIV_W   = $clog2(SLOW_DIV + 1)
) (
  input  mode_e             cur,
  input  logic              sub_stop,
  input  logic              nf_fast,
  output logic              main_clk_en,
  output logic              sub_clk_en,
  output logic [DIV_W-1:0]  smp_div
);
  logic [7:0] div8;

  assign main_clk_en = main_on(cur);
  assign sub_clk_en  = ~sub_stop;
  assign div8        = pick_div(nf_fast, 8'(FAST_DIV), 8'(SLOW_DIV));
  assign smp_div     = div8[DIV_W-1:0];
endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
  import lpm_pkg::*;
#(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 32,
  localparam int DIV_W   = $clog2(SLOW_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             wake_evt,
  input  logic             lo_spd,
  input  logic             stby_sel,
  input  logic             dir_xfer,
  input  logic             sub_stop,
  input  logic             nf_fast,
  input  logic             div_sel,
  output logic [2:0]       mode,
  output logic             main_clk_en,
  output logic             sub_clk_en,
  output logic [DIV_W-1:0] smp_div
);
  mode_e mode_q;
  mode_e mode_d;
  logic  refused;   // event: a subclock mode was refused

  lpm_next_mode u_next (
    .cur(mode_q), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .lo_spd(lo_spd), .stby_sel(stby_sel), .dir_xfer(dir_xfer),
    .sub_off(sub_stop), .div_sel(div_sel), .nxt(mode_d), .refused(refused)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_FULL;
    else        mode_q <= mode_d;
  end

  lpm_clk_ctrl #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_clk (
    .cur(mode_q), .sub_stop(sub_stop), .nf_fast(nf_fast),
    .main_clk_en(main_clk_en), .sub_clk_en(sub_clk_en), .smp_div(smp_div)
  );

  assign mode = mode_q;

  // R7: with the subclock off, no subclock mode is entered from outside
  p_no_sub_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_stop && !needs_sub(mode_q)) |=> !needs_sub(mode_q));

  // R7: a refused request leaves the mode as it was
  p_refused_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> (mode_q == $past(mode_q)));

  // R8: sleep exits to full speed on wake
  p_sleep_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLEEP && wake_evt) |=> (mode_q == M_FULL));

  // R9: watch exit on the main-clock path
  p_watch_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WATCH && wake_evt && !lo_spd) |=> (mode_q == M_FULL));

  // R10: parked states ignore everything but a wake event
  p_parked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_parked(mode_q) && !wake_evt) |=> $stable(mode_q));

  // R11: main clock is off whenever the subclock path runs
  p_main_off_sub_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SUBACT) |-> !main_clk_en);
endmodule

// File: tb/lpm_mode_ctrl_tb.sv
module lpm_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, wake_evt = 0, lo_spd = 0, stby_sel = 0;
  logic dir_xfer = 0, sub_stop = 0, nf_fast = 0, div_sel = 0;
  logic [2:0] mode;
  logic main_clk_en, sub_clk_en;
  logic [5:0] smp_div;

  int errs = 0;
  int checks = 0;
  logic [2:0] exp_mode;
  logic done = 1'b0;

  always #4 clk = ~clk;

  lpm_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .lo_spd(lo_spd), .stby_sel(stby_sel), .dir_xfer(dir_xfer),
    .sub_stop(sub_stop), .nf_fast(nf_fast), .div_sel(div_sel),
    .mode(mode), .main_clk_en(main_clk_en), .sub_clk_en(sub_clk_en),
    .smp_div(smp_div)
  );

  // mode codes: 0 full, 1 div, 2 subact, 3 sleep, 4 subsleep, 5 standby, 6 watch
  function automatic logic on_sub(logic [2:0] m);
    return m == 3'd2 || m == 3'd4 || m == 3'd6;
  endfunction

  function automatic logic [2:0] ref_next(logic [2:0] m, logic s, logic w,
      logic ls, logic sb, logic dx, logic ss, logic dv);
    logic [2:0] t;
    t = m;
    if (m <= 3'd1) begin
      if (!s)      t = dv ? 3'd1 : 3'd0;
      else if (ls) t = sb ? 3'd6 : 3'd2;
      else         t = !sb ? 3'd3 : (dx ? 3'd6 : 3'd5);
    end else if (m == 3'd2) begin
      if (s) t = ls ? (sb ? 3'd6 : 3'd4) : (dx ? 3'd0 : 3'd6);
    end else if (w) begin
      if (m == 3'd4)      t = 3'd2;
      else if (m == 3'd6) t = ls ? 3'd2 : 3'd0;
      else                t = 3'd0;
    end
    if (ss && on_sub(t) && t != m) t = m;
    return t;
  endfunction

  function automatic string tag_of(logic [2:0] m, logic [2:0] n);
    if (sub_stop && on_sub(ref_next(m, sleep_req, wake_evt, lo_spd, stby_sel, dir_xfer, 1'b0, div_sel))
        && n == m && (sleep_req || wake_evt)) return "R7";
    if (m <= 3'd1) return sleep_req ? (lo_spd ? "R4" : "R3") : "R2";
    if (m == 3'd2) return sleep_req ? (lo_spd ? "R6" : "R5") : "R10";
    if (!wake_evt) return "R10";
    return (m == 3'd6) ? "R9" : "R8";
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    logic exp_main;
    exp_main = !(exp_mode == 3'd5 || exp_mode == 3'd6 || exp_mode == 3'd2 || exp_mode == 3'd4);
    chk(tag, {5'd0, mode}, {5'd0, exp_mode});
    chk("R11 main_clk_en", {7'd0, main_clk_en}, {7'd0, exp_main});
    chk("R11 sub_clk_en", {7'd0, sub_clk_en}, {7'd0, !sub_stop});
    chk("R12 smp_div", {2'd0, smp_div}, nf_fast ? 8'd4 : 8'd32);
  endtask

  task automatic step(logic s, logic w, logic ls, logic sb, logic dx,
                      logic ss, logic nf, logic dv);
    string tg;
    sleep_req = s; wake_evt = w; lo_spd = ls; stby_sel = sb;
    dir_xfer = dx; sub_stop = ss; nf_fast = nf; div_sel = dv;
    tg = tag_of(exp_mode, ref_next(exp_mode, s, w, ls, sb, dx, ss, dv));
    exp_mode = ref_next(exp_mode, s, w, ls, sb, dx, ss, dv);
    @(negedge clk);
    check_outs(tg);
  endtask

  initial begin
    void'($urandom(32'd1234));
    exp_mode = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_outs("R1 reset");
    // directed: R7 refusal from full speed toward subactive
    step(1, 0, 1, 0, 0, 1, 0, 0);
    // R2 divided speed, then R3 sleep and R8 wake
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);   // R10 ignored
    step(0, 1, 0, 0, 0, 0, 0, 0);
    // R4 to subactive, R6 subsleep, R8 back, R5 direct to full
    step(1, 0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 1, 0, 0, 0);
    // R3 watch, R9 exit with subclock stopped then allowed
    step(1, 0, 0, 1, 1, 0, 1, 0);
    step(0, 1, 1, 0, 0, 1, 0, 0);
    step(0, 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) == 0, ($urandom % 3) == 0, 1'($urandom), 1'($urandom),
           1'($urandom), ($urandom % 8) == 0, 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule